// File: doc/BRIEF.md
# Bus Cycle Status Decoder

This block sits next to an 8-bit processor bus and turns the processor's per-cycle status byte into individual command strobes. At the start of each machine cycle the processor raises a status-valid marker and places a status byte on the data bus. The block stores that byte and keeps it until the next marked cycle.

For the rest of the machine cycle the block combines the stored bits with the processor's active-high read strobe and active-low write strobe. From these it produces separate strobes for memory read, memory write, port read, port write and interrupt acknowledge. It also reports whether the cycle is a stack access, an opcode fetch or a halt. For port cycles it outputs a port number taken from one selectable half of the address bus, because the processor repeats the port number in both halves.

Top module: `bus_cycle_decoder`

## Requirements
- R1: A synchronous active-low reset clears the stored status to all zeros. After reset, with the read strobe low and the write strobe high, every output strobe and flag is low.
- R2: The status byte is stored on a rising clock edge where the status-valid marker is high. On every other edge the stored byte keeps its value, whatever happens on the data bus.
- R3: Memory read is high when stored bit 7 (memory read) is set, stored bit 0 is clear and the read strobe is high.
- R4: Port read is high when stored bit 6 (input port) is set and the read strobe is high.
- R5: Memory write is high when stored bit 1 (high means read, low means write) is low, stored bit 4 is clear and the write strobe is low.
- R6: Port write is high when stored bit 4 (output port) is set and the write strobe is low.
- R7: Interrupt acknowledge is high when stored bit 0 is set and the read strobe is high. While bit 0 is stored, memory read stays low even if bit 7 is also set.
- R8: The stack flag follows stored bit 2, the halt flag follows stored bit 3 and the fetch flag follows stored bit 5, without regard to either strobe.
- R9: The port number output equals the upper half of the address bus when PORT_HI is 1 and the lower half when PORT_HI is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Status-valid marker; data_i carries the status byte |
| data_i | input | 8 | Processor data bus |
| rd_i | input | 1 | Processor read strobe, active high |
| wr_n_i | input | 1 | Processor write strobe, active low |
| addr_i | input | ADDR_W | Processor address bus |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Memory write command |
| io_rd_o | output | 1 | Port read command |
| io_wr_o | output | 1 | Port write command |
| inta_o | output | 1 | Interrupt acknowledge command |
| stack_o | output | 1 | Cycle is a stack access |
| halt_o | output | 1 | Processor is halted |
| fetch_o | output | 1 | Cycle is an opcode fetch |
| port_o | output | ADDR_W/2 | Port number from the selected address half |

## Verification
The bench builds the decoder with ADDR_W of 16 and PORT_HI set to 1. The bench drives addresses whose two halves differ, so that a port number taken from the wrong half shows up at once. The default PORT_HI of 0 is still elaborated by the lint run. With the 16-bit address, the directed status bytes and a long random stretch reach every strobe combination. That stretch includes a status byte that has both the interrupt and memory-read bits set, and stretches in which the data bus changes without a status-valid marker.

// File: rtl/bsd_pkg.sv
// Package: shared status-bit positions and the command strobe bundle.
// Assumes the status byte is eight bits with fixed bit meanings.
package bsd_pkg;
    localparam int ST_W     = 8;
    localparam int ST_INTA  = 0;
    localparam int ST_READ  = 1;
    localparam int ST_STACK = 2;
    localparam int ST_HALT  = 3;
    localparam int ST_OUT   = 4;
    localparam int ST_FETCH = 5;
    localparam int ST_IN    = 6;
    localparam int ST_MEM   = 7;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic inta;
    } cmd_t;
endpackage

// File: rtl/status_latch.sv
// Module: holds the status byte captured in the marked cycle.
// Assumes the marker is synchronous to clk; reset is synchronous, active low.
module status_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture on the marker, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/strobe_gen.sv
// Module: decodes the stored status byte and the live strobes into commands.
// Assumes rd is active high and wr_n is active low; purely combinational.
module strobe_gen
    import bsd_pkg::*;
(
    input  logic [ST_W-1:0] st,
    input  logic            rd,
    input  logic            wr_n,
    output cmd_t            cmd
);
    logic wr;

    // Bring the write strobe to active-high form.
    always_comb wr = ~wr_n;

    // Form each command; interrupt acknowledge takes priority over memory read.
    always_comb begin
        cmd.inta   = st[ST_INTA] & rd;
        cmd.mem_rd = st[ST_MEM] & ~st[ST_INTA] & rd;
        cmd.io_rd  = st[ST_IN] & rd;
        cmd.io_wr  = st[ST_OUT] & wr;
        cmd.mem_wr = ~st[ST_READ] & ~st[ST_OUT] & wr;
    end
endmodule

// File: rtl/port_pick.sv
// Module: selects which address half carries the port number.
// Assumes ADDR_W is even; PORT_HI picks the upper half.
module port_pick #(
    parameter int ADDR_W  = 16,
    parameter bit PORT_HI = 1'b0
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [ADDR_W/2-1:0] port
);
    localparam int HALF = ADDR_W / 2;

    generate
        if (PORT_HI) begin : g_hi
            // Take the upper address half.
            always_comb port = addr[ADDR_W-1:HALF];
        end else begin : g_lo
            // Take the lower address half.
            always_comb port = addr[HALF-1:0];
        end
    endgenerate
endmodule

// File: rtl/bus_cycle_decoder.sv
// Top: captures the processor status byte and issues per-cycle commands.
// Assumes a single clock domain with synchronous active-low reset.
module bus_cycle_decoder
    import bsd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter bit PORT_HI = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_i,
    input  logic [ST_W-1:0]     data_i,
    input  logic                rd_i,
    input  logic                wr_n_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                mem_rd_o,
    output logic                mem_wr_o,
    output logic                io_rd_o,
    output logic                io_wr_o,
    output logic                inta_o,
    output logic                stack_o,
    output logic                halt_o,
    output logic                fetch_o,
    output logic [ADDR_W/2-1:0] port_o
);
    logic [ST_W-1:0] status_q;
    cmd_t            cmd;

    status_latch #(.W(ST_W)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .load (sync_i),
        .d    (data_i),
        .q    (status_q)
    );

    strobe_gen u_strobe (
        .st  (status_q),
        .rd  (rd_i),
        .wr_n(wr_n_i),
        .cmd (cmd)
    );

    port_pick #(.ADDR_W(ADDR_W), .PORT_HI(PORT_HI)) u_port (
        .addr(addr_i),
        .port(port_o)
    );

    // Drive the command and flag outputs.
    always_comb begin
        mem_rd_o = cmd.mem_rd;
        mem_wr_o = cmd.mem_wr;
        io_rd_o  = cmd.io_rd;
        io_wr_o  = cmd.io_wr;
        inta_o   = cmd.inta;
        stack_o  = status_q[ST_STACK];
        halt_o   = status_q[ST_HALT];
        fetch_o  = status_q[ST_FETCH];
    end
endmodule

// File: rtl/bus_cycle_decoder_chk.sv
// Checker: temporal properties of the decoder, observed at its ports.
module bus_cycle_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_i,
    input logic [7:0] data_i,
    input logic       rd_i,
    input logic       wr_n_i,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input logic       io_rd_o,
    input logic       io_wr_o,
    input logic       inta_o,
    input logic       stack_o,
    input logic       halt_o,
    input logic       fetch_o
);
    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && rst_n) |=> ($stable(stack_o) && $stable(halt_o) && $stable(fetch_o))); // R2
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && rst_n) |=> (stack_o == $past(data_i[2]) && halt_o == $past(data_i[3]))); // R8
    AST_INTA_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !(inta_o && mem_rd_o)); // R7
    AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_o && io_wr_o)); // R5
    AST_IO_RD_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd_o |-> rd_i); // R4
    AST_IO_WR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr_o |-> !wr_n_i); // R6
    AST_MEM_RD_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> rd_i); // R3
endmodule

bind bus_cycle_decoder bus_cycle_decoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .data_i  (data_i),
    .rd_i    (rd_i),
    .wr_n_i  (wr_n_i),
    .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o),
    .io_rd_o (io_rd_o),
    .io_wr_o (io_wr_o),
    .inta_o  (inta_o),
    .stack_o (stack_o),
    .halt_o  (halt_o),
    .fetch_o (fetch_o)
);

// File: tb/bus_cycle_decoder_tb.sv
// Bench: behavioural reference model, compared on every clock at the falling edge.
module bus_cycle_decoder_tb;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_i = 1'b0;
    logic [7:0]        data_i = 8'h00;
    logic              rd_i = 1'b0;
    logic              wr_n_i = 1'b1;
    logic [ADDR_W-1:0] addr_i = '0;
    logic mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, inta_o, stack_o, halt_o, fetch_o;
    logic [ADDR_W/2-1:0] port_o;

    int checks = 0;
    int fails  = 0;
    int model_st = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_decoder #(.ADDR_W(ADDR_W), .PORT_HI(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .data_i(data_i),
        .rd_i(rd_i), .wr_n_i(wr_n_i), .addr_i(addr_i),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .io_rd_o(io_rd_o),
        .io_wr_o(io_wr_o), .inta_o(inta_o), .stack_o(stack_o),
        .halt_o(halt_o), .fetch_o(fetch_o), .port_o(port_o)
    );

    // Reference status register (R1, R2).
    always @(posedge clk) begin
        if (!rst_n) model_st = 0;
        else if (sync_i) model_st = int'(data_i);
    end

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit b0, b1, b4, b5, b6, b7, rd, wr;
        b0 = model_st[0]; b1 = model_st[1]; b4 = model_st[4];
        b5 = model_st[5]; b6 = model_st[6]; b7 = model_st[7];
        rd = rd_i; wr = !wr_n_i;
        cmp("R3 mem_rd", int'(mem_rd_o), int'(b7 && !b0 && rd));
        cmp("R4 io_rd",  int'(io_rd_o),  int'(b6 && rd));
        cmp("R5 mem_wr", int'(mem_wr_o), int'(!b1 && !b4 && wr));
        cmp("R6 io_wr",  int'(io_wr_o),  int'(b4 && wr));
        cmp("R7 inta",   int'(inta_o),   int'(b0 && rd));
        cmp("R8 stack",  int'(stack_o),  int'(model_st[2]));
        cmp("R8 halt",   int'(halt_o),   int'(model_st[3]));
        cmp("R8 fetch",  int'(fetch_o),  int'(b5));
        cmp("R9 port",   int'(port_o),   int'(addr_i[15:8]));
    endtask

    // One clock: check the outputs of the previous edge, then drive new inputs.
    task automatic step(input bit s, input logic [7:0] d, input bit r, input bit wn,
                        input logic [15:0] a);
        @(negedge clk);
        check_all();
        sync_i = s; data_i = d; rd_i = r; wr_n_i = wn; addr_i = a;
    endtask

    // Status cycle followed by a strobe cycle.
    task automatic mcycle(input logic [7:0] st, input bit r, input bit wn, input logic [15:0] a);
        step(1'b1, st, 1'b0, 1'b1, a);
        step(1'b0, 8'h5A, r, wn, a);
        step(1'b0, 8'hA5, r, wn, a);
        step(1'b0, 8'h00, 1'b0, 1'b1, a);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(1'b0, 8'hFF, 1'b0, 1'b1, 16'h0000);
        // R1: outputs all low after reset.
        @(negedge clk);
        cmp("R1 reset mem_rd", int'(mem_rd_o), 0);
        cmp("R1 reset stack",  int'(stack_o), 0);
        cmp("R1 reset halt",   int'(halt_o), 0);
        rst_n = 1'b1;
        mcycle(8'hA2, 1'b1, 1'b1, 16'h1234); // R3 fetch from memory
        mcycle(8'h86, 1'b1, 1'b1, 16'hFF00); // R3 R8 stack read
        mcycle(8'h00, 1'b0, 1'b0, 16'h4321); // R5 memory write
        mcycle(8'h04, 1'b0, 1'b0, 16'h1111); // R5 R8 stack write
        mcycle(8'h10, 1'b0, 1'b0, 16'h3412); // R6 port write
        mcycle(8'h42, 1'b1, 1'b1, 16'h7856); // R4 port read
        mcycle(8'h23, 1'b1, 1'b1, 16'h0000); // R7 interrupt ack
        mcycle(8'hA3, 1'b1, 1'b1, 16'h0000); // R7 ack overrides memory read
        mcycle(8'h8A, 1'b0, 1'b1, 16'h0000); // R8 halt
        // R2: data changes without the marker must not disturb the stored byte.
        for (int i = 0; i < 8; i++) step(1'b0, 8'(i * 37), 1'b1, 1'b0, 16'(i * 4099));
        // R1: reset in mid-run clears the stored byte.
        rst_n = 1'b0;
        step(1'b0, 8'hFF, 1'b0, 1'b1, 16'h0000);
        rst_n = 1'b1;
        step(1'b0, 8'hFF, 1'b0, 1'b1, 16'h0000);
        for (int i = 0; i < 400; i++)
            step(1'($urandom_range(0, 3) == 0), 8'($urandom), 1'($urandom),
                 1'($urandom), 16'($urandom));
        step(1'b0, 8'h00, 1'b0, 1'b1, 16'h0000);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule